// File: doc/BRIEF.md
# Composite Video Line Pattern Generator

This block produces a synthetic composite-video scan line, one signed sample per clock, and repeats it for as long as it is enabled. It serves as a test source for a video datapath such as a pre-emphasis filter in front of a DAC. Each line is 1716 samples long (one line at 27 MS/s). It contains blanking at zero, a sync pulse with raised-cosine edges, a subcarrier burst, an active region where a luminance ramp carries a chroma sine, and a linear descent back to black.

Inside the block, levels are integers in eighths of an IRE unit (one IRE is 1/140 V). The subcarrier sine comes from a 16-bit phase accumulator and a quarter-wave table. The slow ramps are produced by exact quotient/remainder steppers. The level is then scaled to volts with 9 fractional bits and clamped to a 10-bit signed word. Raising `run_i` starts a line at sample 1; lowering it returns the block to idle.

Top module: `vpg_line_gen`

## Requirements
- R1: While reset is applied, and whenever the block is idle, `valid_o`, `line_start_o` and `sample_o` are all 0.
- R2: When `run_i` is sampled high at a clock edge while the block is idle, the first output sample (sample 1) appears after the following edge, with `valid_o` and `line_start_o` both 1. After the first edge alone, `valid_o` is still 0.
- R3: While `run_i` stays high, samples are numbered 1 to 1716 and then wrap to 1. `line_start_o` is 1 on sample 1 only.
- R4: `sample_o` equals floor(L·7490/16384) clamped to [-512, 511], where L is the level of the sample in units of 1/8 IRE.
- R5: Samples 1–32, 179 and 248–259 have L = 0.
- R6: Let E[k] = round(320·sin²(πk/16)). Sample 33+k has L = −E[k] for k = 0..7. Samples 41–170 have L = −320. Sample 178−k has L = −E[k] for k = 0..7.
- R7: Let S(n) = round(160·sin(2π(i+0.5)/64)), where i is bits 15:10 of (n·8688 mod 65536) and rounding is symmetric about zero. Sample s in 180–247 has L = S(s−180).
- R8: For sample s in 260–1675, with a = s−259, L = 60 + floor(580·a/1416) + S(a).
- R9: For sample s in 1676–1716, with m = 1717−s, L = floor(580·m/41). This value never rises from one sample to the next.
- R10: When `run_i` is sampled low, `valid_o` is 0 from the second following edge onward. A later start begins again at sample 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Sample clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| run_i | input | 1 | High: generate lines; low: return to idle |
| sample_o | output | 10 | Signed level in volts, 9 fractional bits |
| line_start_o | output | 1 | High on sample 1 of each line |
| valid_o | output | 1 | High while `sample_o` carries a line sample |

## Verification
The assertions assume that `run_i` changes only between clock edges. They also assume that the pattern levels never reach the clamp, so the sync tip always maps to a single code and the tail is monotonic. The checker tracks the sample index from `line_start_o` and `valid_o` alone. It therefore relies on the block restarting at sample 1 after every idle period. The bench drives `run_i` only at falling edges. It starts the block from idle twice, once after reset and once after stopping it mid-line, and it never clamps the levels, which keeps every assumption true.

// File: rtl/vpg_pkg.sv
package vpg_pkg;
  // Segment boundaries, 1-based sample index within a line
  localparam int SYNC_FALL_FIRST = 33;
  localparam int SYNC_TIP_FIRST  = 41;
  localparam int SYNC_RISE_FIRST = 171;
  localparam int SYNC_RISE_LAST  = 178;
  localparam int BURST_FIRST     = 180;
  localparam int BURST_LAST      = 247;
  localparam int ACT_FIRST       = 260;
  localparam int ACT_LAST        = 1675;
  localparam int TAIL_FIRST      = 1676;

  // Levels in 1/8 IRE
  localparam int LVL_TIP   = -320;
  localparam int ACT_BASE  = 60;
  localparam int RAMP_SPAN = 580;
  localparam int ACT_LEN   = ACT_LAST - ACT_FIRST + 1;
  localparam int TAIL_STEPS = 41;

  // Volts with 9 fractional bits: code = (L * SCALE) >>> SCALE_SHIFT
  localparam int SCALE       = 7490;
  localparam int SCALE_SHIFT = 14;

  // Sync edge magnitude, round(320 * sin^2(pi*k/16))
  function automatic logic [8:0] edge_mag(input logic [2:0] k);
    case (k)
      3'd0: edge_mag = 9'd0;
      3'd1: edge_mag = 9'd12;
      3'd2: edge_mag = 9'd47;
      3'd3: edge_mag = 9'd99;
      3'd4: edge_mag = 9'd160;
      3'd5: edge_mag = 9'd221;
      3'd6: edge_mag = 9'd273;
      default: edge_mag = 9'd308;
    endcase
  endfunction
endpackage

// File: rtl/vpg_subcarrier.sv
module vpg_subcarrier #(
  parameter int PH_W   = 16,
  parameter int PH_INC = 8688,
  parameter int AMP_W  = 9
) (
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic                    clr_i,
  output logic signed [AMP_W-1:0] sin_o
);
  localparam int QI_W = 4;
  localparam logic [PH_W-1:0] INC = PH_W'(PH_INC);

  logic [PH_W-1:0] phase_q, phase_d;
  logic [QI_W-1:0] qidx;
  logic [7:0]      mag;

  // round(160 * sin(2*pi*(i+0.5)/64)), first quadrant
  function automatic logic [7:0] quarter(input logic [QI_W-1:0] i);
    case (i)
      4'd0:  quarter = 8'd8;
      4'd1:  quarter = 8'd23;
      4'd2:  quarter = 8'd39;
      4'd3:  quarter = 8'd54;
      4'd4:  quarter = 8'd68;
      4'd5:  quarter = 8'd82;
      4'd6:  quarter = 8'd95;
      4'd7:  quarter = 8'd107;
      4'd8:  quarter = 8'd119;
      4'd9:  quarter = 8'd129;
      4'd10: quarter = 8'd137;
      4'd11: quarter = 8'd145;
      4'd12: quarter = 8'd151;
      4'd13: quarter = 8'd155;
      4'd14: quarter = 8'd158;
      default: quarter = 8'd160;
    endcase
  endfunction

  always_comb begin
    phase_d = clr_i ? '0 : phase_q + INC;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) phase_q <= '0;
    else        phase_q <= phase_d;
  end

  always_comb begin
    qidx  = phase_q[PH_W-2] ? ~phase_q[PH_W-3 -: QI_W] : phase_q[PH_W-3 -: QI_W];
    mag   = quarter(qidx);
    sin_o = phase_q[PH_W-1] ? -AMP_W'(mag) : AMP_W'(mag);
  end
endmodule

// File: rtl/vpg_ramp.sv
module vpg_ramp #(
  parameter int QW       = 11,
  parameter int UP_NUM   = 580,
  parameter int UP_DEN   = 1416,
  parameter int DN_START = 580,
  parameter int DN_DEN   = 41
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          up_clr_i,
  input  logic          up_step_i,
  input  logic          dn_load_i,
  input  logic          dn_step_i,
  output logic [QW-1:0] q_o
);
  localparam int RW = $clog2(UP_DEN) + 1;
  localparam logic [RW-1:0] UP_NUM_C = RW'(UP_NUM);
  localparam logic [RW-1:0] UP_DEN_C = RW'(UP_DEN);
  localparam logic [RW-1:0] DN_R_C   = RW'(DN_START % DN_DEN);
  localparam logic [RW-1:0] DN_DEN_C = RW'(DN_DEN);
  localparam logic [QW-1:0] DN_Q_C   = QW'(DN_START / DN_DEN);
  localparam logic [QW-1:0] DN_LOAD  = QW'(DN_START);

  logic [QW-1:0] q_q, q_d;
  logic [RW-1:0] r_q, r_d, up_sum;

  always_comb begin
    q_d    = q_q;
    r_d    = r_q;
    up_sum = r_q + UP_NUM_C;
    if (up_clr_i) begin
      q_d = '0;
      r_d = '0;
    end else if (dn_load_i) begin
      q_d = DN_LOAD;
      r_d = '0;
    end else if (up_step_i) begin
      if (up_sum >= UP_DEN_C) begin
        r_d = up_sum - UP_DEN_C;
        q_d = q_q + QW'(1);
      end else begin
        r_d = up_sum;
      end
    end else if (dn_step_i) begin
      if (r_q < DN_R_C) begin
        r_d = r_q + DN_DEN_C - DN_R_C;
        q_d = q_q - DN_Q_C - QW'(1);
      end else begin
        r_d = r_q - DN_R_C;
        q_d = q_q - DN_Q_C;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      q_q <= '0;
      r_q <= '0;
    end else begin
      q_q <= q_d;
      r_q <= r_d;
    end
  end

  assign q_o = q_q;
endmodule

// File: rtl/vpg_line_gen.sv
module vpg_line_gen
  import vpg_pkg::*;
#(
  parameter int LINE_LEN = 1716,
  parameter int OUT_W    = 10,
  parameter int LVL_W    = 12,
  parameter int PH_W     = 16,
  parameter int PH_INC   = 8688,
  parameter int RAMP_QW  = 11
) (
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic                    run_i,
  output logic signed [OUT_W-1:0] sample_o,
  output logic                    line_start_o,
  output logic                    valid_o
);
  localparam int CW    = $clog2(LINE_LEN + 1);
  localparam int AMP_W = 9;
  localparam int PW    = LVL_W + 15;
  localparam logic [CW-1:0] C_LAST  = CW'(LINE_LEN);
  localparam logic [CW-1:0] C_FALL  = CW'(SYNC_FALL_FIRST);
  localparam logic [CW-1:0] C_TIP   = CW'(SYNC_TIP_FIRST);
  localparam logic [CW-1:0] C_RISE  = CW'(SYNC_RISE_FIRST);
  localparam logic [CW-1:0] C_RISEL = CW'(SYNC_RISE_LAST);
  localparam logic [CW-1:0] C_BST   = CW'(BURST_FIRST);
  localparam logic [CW-1:0] C_BSTL  = CW'(BURST_LAST);
  localparam logic [CW-1:0] C_ACT   = CW'(ACT_FIRST);
  localparam logic [CW-1:0] C_ACTL  = CW'(ACT_LAST);
  localparam logic [CW-1:0] C_TAIL  = CW'(TAIL_FIRST);
  localparam logic signed [LVL_W-1:0] TIP_L  = LVL_W'(LVL_TIP);
  localparam logic signed [LVL_W-1:0] BASE_L = LVL_W'(ACT_BASE);
  localparam logic signed [PW-1:0] SCALE_W = PW'(SCALE);
  localparam logic signed [PW-1:0] OMAX = PW'((2 ** (OUT_W - 1)) - 1);
  localparam logic signed [PW-1:0] OMIN = PW'(-(2 ** (OUT_W - 1)));

  logic [1:0]    rs_q;
  logic          core_rst_n;
  logic [CW-1:0] cnt_q, cnt_d;
  logic          ph_clr, up_clr, up_step, dn_load, dn_step;
  logic signed [AMP_W-1:0] sin_v;
  logic [RAMP_QW-1:0]      ramp_q;
  logic signed [LVL_W-1:0] lvl;
  logic signed [PW-1:0]    prod, scaled;
  logic signed [OUT_W-1:0] code_c;

  // Reset: asserted asynchronously, released after two clock edges
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rs_q <= '0;
    else        rs_q <= {rs_q[0], 1'b1};
  end
  assign core_rst_n = rs_q[1];

  // Sample sequencer; cnt_q == 0 means idle
  always_comb begin
    if (!run_i)                              cnt_d = '0;
    else if (cnt_q == '0 || cnt_q == C_LAST) cnt_d = CW'(1);
    else                                     cnt_d = cnt_q + CW'(1);
    ph_clr  = (cnt_d == C_BST) || (cnt_d == C_ACT - CW'(1));
    up_clr  = (cnt_d == C_ACT - CW'(1));
    up_step = (cnt_d >= C_ACT) && (cnt_d <= C_ACTL);
    dn_load = (cnt_d == C_TAIL);
    dn_step = (cnt_d > C_TAIL) && (cnt_d <= C_LAST);
  end

  always_ff @(posedge clk or negedge core_rst_n) begin
    if (!core_rst_n) cnt_q <= '0;
    else             cnt_q <= cnt_d;
  end

  vpg_subcarrier #(.PH_W(PH_W), .PH_INC(PH_INC), .AMP_W(AMP_W)) u_sub (
    .clk   (clk),
    .rst_n (core_rst_n),
    .clr_i (ph_clr),
    .sin_o (sin_v)
  );

  vpg_ramp #(
    .QW(RAMP_QW), .UP_NUM(RAMP_SPAN), .UP_DEN(ACT_LEN),
    .DN_START(RAMP_SPAN), .DN_DEN(TAIL_STEPS)
  ) u_ramp (
    .clk       (clk),
    .rst_n     (core_rst_n),
    .up_clr_i  (up_clr),
    .up_step_i (up_step),
    .dn_load_i (dn_load),
    .dn_step_i (dn_step),
    .q_o       (ramp_q)
  );

  // Level of the current sample in 1/8 IRE
  always_comb begin
    lvl = '0;
    if (cnt_q >= C_FALL && cnt_q < C_TIP)
      lvl = -signed'(LVL_W'(edge_mag(3'(cnt_q - C_FALL))));
    else if (cnt_q >= C_TIP && cnt_q < C_RISE)
      lvl = TIP_L;
    else if (cnt_q >= C_RISE && cnt_q <= C_RISEL)
      lvl = -signed'(LVL_W'(edge_mag(3'(C_RISEL - cnt_q))));
    else if (cnt_q >= C_BST && cnt_q <= C_BSTL)
      lvl = LVL_W'(sin_v);
    else if (cnt_q >= C_ACT && cnt_q <= C_ACTL)
      lvl = BASE_L + signed'(LVL_W'(ramp_q)) + LVL_W'(sin_v);
    else if (cnt_q >= C_TAIL && cnt_q <= C_LAST)
      lvl = signed'(LVL_W'(ramp_q));
  end

  // Scale to volts (9 fractional bits), floor, clamp
  always_comb begin
    prod   = PW'(lvl) * SCALE_W;
    scaled = prod >>> SCALE_SHIFT;
    if (scaled > OMAX)      code_c = OMAX[OUT_W-1:0];
    else if (scaled < OMIN) code_c = OMIN[OUT_W-1:0];
    else                    code_c = scaled[OUT_W-1:0];
  end

  always_ff @(posedge clk or negedge core_rst_n) begin
    if (!core_rst_n) begin
      sample_o     <= '0;
      line_start_o <= 1'b0;
      valid_o      <= 1'b0;
    end else begin
      sample_o     <= code_c;
      line_start_o <= (cnt_q == CW'(1));
      valid_o      <= (cnt_q != '0);
    end
  end
endmodule

// File: rtl/vpg_line_gen_chk.sv
module vpg_line_gen_chk
  import vpg_pkg::*;
#(
  parameter int LINE_LEN = 1716,
  parameter int OUT_W    = 10
) (
  input logic                    clk,
  input logic                    rst_n,
  input logic                    run_i,
  input logic signed [OUT_W-1:0] sample_o,
  input logic                    line_start_o,
  input logic                    valid_o
);
  localparam int CW = $clog2(LINE_LEN + 1);
  localparam int TIP_CODE = (LVL_TIP * SCALE) >>> SCALE_SHIFT;

  logic [CW-1:0] pos_q, pos_c;

  assign pos_c = line_start_o ? CW'(1) : pos_q + CW'(1);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)       pos_q <= '0;
    else if (valid_o) pos_q <= pos_c;
    else              pos_q <= '0;
  end

  AST_IDLE_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
    !valid_o |-> (sample_o == '0 && !line_start_o)); // R1

  AST_START_AT_ONE: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(valid_o) |-> line_start_o); // R2

  AST_LINE_WRAP: assert property (@(posedge clk) disable iff (!rst_n)
    (valid_o && $past(valid_o)) |-> (line_start_o == (pos_q == CW'(LINE_LEN)))); // R3

  AST_BLANK_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
    (valid_o && (pos_c < CW'(SYNC_FALL_FIRST) || pos_c == CW'(SYNC_RISE_LAST + 1) ||
     (pos_c > CW'(BURST_LAST) && pos_c < CW'(ACT_FIRST)))) |-> sample_o == '0); // R5

  AST_SYNC_TIP: assert property (@(posedge clk) disable iff (!rst_n)
    (valid_o && pos_c >= CW'(SYNC_TIP_FIRST) && pos_c < CW'(SYNC_RISE_FIRST))
      |-> int'(sample_o) == TIP_CODE); // R6

  AST_TAIL_FALLS: assert property (@(posedge clk) disable iff (!rst_n)
    (valid_o && pos_c > CW'(TAIL_FIRST) && pos_c <= CW'(LINE_LEN))
      |-> sample_o <= $past(sample_o)); // R9

  AST_STOP_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
    !run_i |-> ##2 !valid_o); // R10
endmodule

bind vpg_line_gen vpg_line_gen_chk #(.LINE_LEN(LINE_LEN), .OUT_W(OUT_W)) u_chk (
  .clk          (clk),
  .rst_n        (rst_n),
  .run_i        (run_i),
  .sample_o     (sample_o),
  .line_start_o (line_start_o),
  .valid_o      (valid_o)
);

// File: tb/tb_vpg_line_gen.sv
`timescale 1ns/1ps
module tb_vpg_line_gen;
  localparam int LINE = 1716;

  logic clk = 1'b0;
  logic rst_n;
  logic run_i;
  logic signed [9:0] sample_o;
  logic line_start_o;
  logic valid_o;
  int n_checks = 0;
  int n_fail = 0;

  always #10 clk = ~clk;

  vpg_line_gen dut (
    .clk(clk), .rst_n(rst_n), .run_i(run_i),
    .sample_o(sample_o), .line_start_o(line_start_o), .valid_o(valid_o)
  );

  function automatic int rnd(input real v);
    if (v >= 0.0) return $rtoi(v + 0.5);
    return -$rtoi(-v + 0.5);
  endfunction

  function automatic int edge_e(input int k);
    real pi = 3.14159265358979;
    real sv = $sin(pi * k / 16.0);
    return rnd(320.0 * sv * sv);
  endfunction

  function automatic int sub_s(input int n);
    real pi = 3.14159265358979;
    int ph = (n * 8688) % 65536;
    int i = ph >> 10;
    return rnd(160.0 * $sin(2.0 * pi * (i + 0.5) / 64.0));
  endfunction

  function automatic int level(input int s);
    if (s >= 33 && s <= 40)     return -edge_e(s - 33);
    if (s >= 41 && s <= 170)    return -320;
    if (s >= 171 && s <= 178)   return -edge_e(178 - s);
    if (s >= 180 && s <= 247)   return sub_s(s - 180);
    if (s >= 260 && s <= 1675)  return 60 + ((s - 259) * 580) / 1416 + sub_s(s - 259);
    if (s >= 1676 && s <= 1716) return (580 * (1717 - s)) / 41;
    return 0;
  endfunction

  function automatic int to_code(input int l);
    int c = (l * 7490) >>> 14;
    if (c > 511) c = 511;
    if (c < -512) c = -512;
    return c;
  endfunction

  function automatic string tag_of(input int s);
    if (s >= 33 && s <= 178)   return "R6";
    if (s >= 180 && s <= 247)  return "R7";
    if (s >= 260 && s <= 1675) return "R8";
    if (s >= 1676)             return "R9";
    return "R5";
  endfunction

  task automatic check_idle(input string tag);
    n_checks++;
    if (valid_o !== 1'b0 || line_start_o !== 1'b0 || sample_o !== 10'sd0) begin
      n_fail++;
      $display("FAIL %s idle: valid=%0b start=%0b sample=%0d expected 0/0/0",
               tag, valid_o, line_start_o, sample_o);
    end
  endtask

  // R3 R4: one check per sample, code and line strobe together
  task automatic check_sample(input int s);
    int exp_c = to_code(level(s));
    n_checks++;
    if (valid_o !== 1'b1 || line_start_o !== (s == 1) || int'(sample_o) != exp_c) begin
      n_fail++;
      $display("FAIL %s/R3/R4 sample %0d: valid=%0b start=%0b code=%0d expected 1/%0b/%0d",
               tag_of(s), s, valid_o, line_start_o, sample_o, (s == 1), exp_c);
    end
  endtask

  initial begin
    rst_n = 1'b0;
    run_i = 1'b0;
    repeat (3) @(posedge clk);
    @(negedge clk);
    check_idle("R1");
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    check_idle("R1");

    // Start: sample 1 after the second edge (R2)
    run_i = 1'b1;
    @(negedge clk);
    check_idle("R2");
    @(negedge clk);
    for (int i = 0; i < 2 * LINE + 100; i++) begin
      check_sample((i % LINE) + 1);
      if (i < 2 * LINE + 99) @(negedge clk);
    end

    // Stop mid-line (R10): one more sample, then idle
    run_i = 1'b0;
    @(negedge clk);
    check_sample(101);
    @(negedge clk);
    check_idle("R10");
    repeat (3) @(negedge clk);
    check_idle("R10");

    // Restart begins again at sample 1 (R10, R2)
    run_i = 1'b1;
    @(negedge clk);
    check_idle("R2");
    @(negedge clk);
    for (int i = 0; i < 300; i++) begin
      check_sample(i + 1);
      if (i < 299) @(negedge clk);
    end

    $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    n_checks++;
    n_fail++;
    $display("FAIL watchdog: run did not complete, actual timeout expected finish");
    $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
    $finish;
  end
endmodule